// File: doc/BRIEF.md
# Two-Lane 2x2 Tile Transposer

This unit reorders a two-lane sample stream between two separable filter passes. The upstream pass produces samples column by column. Each beat carries two vertically adjacent samples: one from an even row and one from the odd row below it, both in the same column. The downstream pass consumes samples row by row. Each of its beats needs two horizontally adjacent samples from one row. The unit turns every pair of incoming beats, which together form a 2x2 tile, into two outgoing beats. The first outgoing beat carries the upper row of the tile and the second carries the lower row.

The unit holds three data registers. The upper-right sample of a tile is never stored: it goes straight from the input to the output selector in the cycle it arrives. The upper row of a tile therefore appears in the same cycle as the tile's second input beat, and the lower row appears in the cycle after it. The next tile's first beat may arrive in that same later cycle, so a gap-free input stream gives a gap-free output stream after the first beat.

Top module: `tile_transposer`

## Requirements
- R1: A synchronous active-high reset deasserts `out_valid` and returns the tile phase to "expecting first beat". The first valid beat after reset is treated as the first beat of a tile, even if reset interrupted a tile.
- R2: In a cycle where a tile's first beat is accepted (`in_valid`=1 in phase "first") and no lower row is pending, `out_valid` is 0.
- R3: In the cycle a tile's second beat is accepted, `out_valid`=1, `out_left` equals the even-lane value of the first beat, and `out_right` equals the even-lane value of the current beat. The path from input to output has no register stage.
- R4: In the cycle after a tile's second beat is accepted, `out_valid`=1, `out_left` equals the odd-lane value of the first beat, and `out_right` equals the odd-lane value of the second beat. This holds whatever `in_valid` is in that cycle.
- R5: Cycles with `in_valid`=0 neither advance the tile phase nor change stored samples. Any number of idle cycles between the two beats of a tile leaves the output rows unchanged.
- R6: A new tile's first beat may be accepted in the same cycle as the previous tile's lower-row output, and that output is not corrupted.
- R7: `out_valid` is 1 only in the cycles named in R3 and R4. Each tile yields exactly two output beats, in input order.
- R8: Lane meaning: `in_even` carries the even (upper) row and `in_odd` carries the odd (lower) row of one column. `out_left` carries the even (left) column and `out_right` carries the odd (right) column of one row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_even | input | DATA_W | Sample from the even (upper) row of the current column |
| in_odd | input | DATA_W | Sample from the odd (lower) row of the current column |
| out_valid | output | 1 | Output beat present |
| out_left | output | DATA_W | Sample from the even (left) column of the current row |
| out_right | output | DATA_W | Sample from the odd (right) column of the current row |

## Verification
The assertions check the control behaviour on every cycle. The upper-row beat and the lower-row beat never collide. A lower-row beat always follows an accepted second beat. Idle cycles freeze the phase and the stored samples. Reset clears the pending row. A first beat on its own raises no output. Data placement cannot be shown by these per-cycle properties, and only the bench scenarios show it: which sample lands on which lane and in which row order, across whole 8x8 blocks sent gap-free, with random idle gaps, and with a reset in the middle of a tile.

// File: rtl/tile_transposer_pkg.sv
package tile_transposer_pkg;

    // Position of the incoming beat within its 2x2 tile
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } tile_phase_e;

    // Which row of the tile the output selectors present
    typedef enum logic {
        ROW_UPPER = 1'b0,
        ROW_LOWER = 1'b1
    } row_sel_e;

    function automatic tile_phase_e next_phase(tile_phase_e cur, logic take);
        if (!take) return cur;
        return (cur == PH_FIRST) ? PH_SECOND : PH_FIRST;
    endfunction

endpackage

// File: rtl/tile_phase_ctrl.sv
module tile_phase_ctrl
    import tile_transposer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output tile_phase_e phase,
    output logic        load_first,
    output logic        load_second,
    output logic        lower_pending,
    output row_sel_e    row_sel,
    output logic        out_valid
);

    logic upper_fire;

    assign load_first  = in_valid && (phase == PH_FIRST);
    assign load_second = in_valid && (phase == PH_SECOND);
    assign upper_fire  = load_second;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase         <= PH_FIRST;
            lower_pending <= 1'b0;
        end else begin
            phase         <= next_phase(phase, in_valid);
            lower_pending <= upper_fire;
        end
    end

    assign row_sel   = lower_pending ? ROW_LOWER : ROW_UPPER;
    assign out_valid = upper_fire || lower_pending;

    AST_NO_ROW_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        !(upper_fire && lower_pending));                              // R6
    AST_LOWER_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        load_second |=> (out_valid && row_sel == ROW_LOWER));         // R4
    AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(phase));                                // R5
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!lower_pending && phase == PH_FIRST));               // R1
    AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (rst)
        (load_first && !lower_pending) |-> !out_valid);               // R2

endmodule

// File: rtl/tile_store.sv
module tile_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_first,
    input  logic              load_second,
    input  logic [DATA_W-1:0] in_even,
    input  logic [DATA_W-1:0] in_odd,
    output logic [DATA_W-1:0] up_left,
    output logic [DATA_W-1:0] low_left,
    output logic [DATA_W-1:0] low_right
);

    always_ff @(posedge clk) begin
        if (load_first) begin
            up_left  <= in_even;
            low_left <= in_odd;
        end
        if (load_second) begin
            low_right <= in_odd;
        end
    end

    AST_STORE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !(load_first || load_second) |=> ($stable(up_left) && $stable(low_left)
                                          && $stable(low_right)));     // R5

endmodule

// File: rtl/row_select.sv
module row_select
    import tile_transposer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  row_sel_e          row_sel,
    input  logic [DATA_W-1:0] up_left,
    input  logic [DATA_W-1:0] up_right,
    input  logic [DATA_W-1:0] low_left,
    input  logic [DATA_W-1:0] low_right,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);

    always_comb begin
        out_left  = (row_sel == ROW_LOWER) ? low_left  : up_left;
        out_right = (row_sel == ROW_LOWER) ? low_right : up_right;
    end

endmodule

// File: rtl/tile_transposer.sv
module tile_transposer
    import tile_transposer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_even,
    input  logic [DATA_W-1:0] in_odd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);

    tile_phase_e       phase;
    row_sel_e          row_sel;
    logic              load_first;
    logic              load_second;
    logic              lower_pending;
    logic [DATA_W-1:0] up_left;
    logic [DATA_W-1:0] low_left;
    logic [DATA_W-1:0] low_right;

    tile_phase_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .phase         (phase),
        .load_first    (load_first),
        .load_second   (load_second),
        .lower_pending (lower_pending),
        .row_sel       (row_sel),
        .out_valid     (out_valid)
    );

    tile_store #(.DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .load_first  (load_first),
        .load_second (load_second),
        .in_even     (in_even),
        .in_odd      (in_odd),
        .up_left     (up_left),
        .low_left    (low_left),
        .low_right   (low_right)
    );

    // upper-right sample bypasses storage (R3)
    row_select #(.DATA_W(DATA_W)) u_sel (
        .row_sel   (row_sel),
        .up_left   (up_left),
        .up_right  (in_even),
        .low_left  (low_left),
        .low_right (low_right),
        .out_left  (out_left),
        .out_right (out_right)
    );

    AST_UPPER_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && phase == PH_SECOND) |-> (out_valid && out_right == in_even)); // R3

endmodule

// File: tb/tile_transposer_bench.sv
module tile_transposer_bench;

    localparam int DW  = 8;
    localparam int BLK = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_even = '0;
    logic [DW-1:0] in_odd = '0;
    logic          out_valid;
    logic [DW-1:0] out_left;
    logic [DW-1:0] out_right;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    // bench-side expectation model
    logic        m_phase = 1'b0;
    logic        m_pend  = 1'b0;
    logic [DW-1:0] exp_l[$];
    logic [DW-1:0] exp_r[$];
    logic        exp_lower[$];
    logic [DW-1:0] blk [BLK][BLK];

    always #2.5 clk = ~clk;   // 200 MHz

    tile_transposer #(.DATA_W(DW)) u_tile_transposer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_even   (in_even),
        .in_odd    (in_odd),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

    // Monitor: samples at the falling edge
    always @(negedge clk) begin
        if (!done) begin
            logic ev;
            ev = !rst && ((in_valid && m_phase) || m_pend);
            checks++;
            if (out_valid !== ev) begin
                errors++;
                $display("FAIL %s out_valid actual=%b expected=%b",
                         rst ? "R1" : (ev ? "R7" : "R2"), out_valid, ev);
            end
            if (ev && out_valid === 1'b1) begin
                checks++;
                if (exp_l.size() == 0) begin
                    errors++;
                    $display("FAIL R7 extra beat actual=%h/%h expected=none", out_left, out_right);
                end else begin
                    logic [DW-1:0] el, er;
                    logic lw;
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    lw = exp_lower.pop_front();
                    if (out_left !== el || out_right !== er) begin
                        errors++;
                        $display("FAIL %s row data actual=%h/%h expected=%h/%h",
                                 lw ? "R4" : "R3", out_left, out_right, el, er);
                    end
                end
            end
            if (rst) begin
                m_phase = 1'b0;
                m_pend  = 1'b0;
            end else begin
                m_pend = in_valid && m_phase;
                if (in_valid) m_phase = ~m_phase;
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_even  = DW'($urandom);
            in_odd   = DW'($urandom);
        end
    endtask

    task automatic beat(logic [DW-1:0] e, logic [DW-1:0] o);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_even  = e;
        in_odd   = o;
    endtask

    // R8: column-scan order; even lane = upper row, expect left/right columns out
    task automatic send_block(int max_gap);
        for (int r = 0; r < BLK; r++)
            for (int c = 0; c < BLK; c++)
                blk[r][c] = DW'($urandom);
        for (int c = 0; c < BLK; c += 2)
            for (int r = 0; r < BLK; r += 2) begin
                exp_l.push_back(blk[r][c]);     exp_r.push_back(blk[r][c+1]);   exp_lower.push_back(1'b0);
                exp_l.push_back(blk[r+1][c]);   exp_r.push_back(blk[r+1][c+1]); exp_lower.push_back(1'b1);
                beat(blk[r][c], blk[r+1][c]);
                if (max_gap > 0) idle($urandom_range(max_gap, 0));   // R5 gaps mid-tile
                beat(blk[r][c+1], blk[r+1][c+1]);
                if (max_gap > 0) idle($urandom_range(max_gap, 0));
            end
    endtask

    task automatic drain_check(string tag);
        idle(3);
        checks++;
        if (exp_l.size() != 0) begin
            errors++;
            $display("FAIL %s beats missing actual=%0d expected=0", tag, exp_l.size());
            exp_l.delete(); exp_r.delete(); exp_lower.delete();
        end
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    errors++;
                    $display("FAIL watchdog actual=timeout expected=completion");
                    done = 1'b1;
                    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                    $finish;
                end
            end
        join_none

        idle(4);
        @(posedge clk); #1; rst = 1'b0;
        // R1 reset state checked by monitor during reset cycles
        // R6 back-to-back tiles with no gaps
        for (int b = 0; b < 4; b++) send_block(0);
        drain_check("R6");
        // R5 idle gaps between and inside tiles
        for (int b = 0; b < 6; b++) send_block(3);
        drain_check("R5");
        // R1 reset in the middle of a tile: next beat is a first beat again
        beat(8'hA1, 8'hB2);
        @(posedge clk); #1; in_valid = 1'b0; rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        send_block(1);
        drain_check("R1");
        // R7 long stream mixing both modes
        for (int b = 0; b < 10; b++) send_block(b % 2);
        drain_check("R7");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule